// File: doc/BRIEF.md
# Serial Port Control and Status Register Front End

This block is the register side of a FIFO-buffered serial port. A simple bus writes and reads byte or halfword values at word-aligned offsets. The block holds the line mode, the baud divisor, the control word, the port pin control word and the FIFO control word. It also tracks five status flags: transmit end, transmit data empty, break seen, receive full and data ready. Software clears a flag by writing a zero to its bit.

The block does not serialise bits, generate the baud clock or store received bytes. The transmit data register passes each written byte to a transmitter as a one-cycle strobe. A separate receive FIFO gets a clear pulse and a trigger level from this block. In return, the FIFO reports its fill level, its head byte and the events that set the receive-side flags. Writes to the control word drive the transmit interrupt line directly. They also gate the receive interrupt line.

Top module: `serial_csr_regs`

## Requirements
- R1: After reset: mode reads 0x00, control reads 0x20, port reads 0x00, FIFO control reads 0x0000, `baud_o` is 0xFF, `rx_trig_o` is 1, both interrupt outputs are low, and status reads 0x60.
- R2: Writes are masked before they are stored. Mode keeps `wdata & 0x7B`. Control keeps `wdata & 0xFA`. Port keeps `wdata & 0xF3`. FIFO control keeps all 16 bits. The baud register keeps 8 bits, which appear on `baud_o`.
- R3: A status write (offset 0x10) clears the flag at bit 6 (transmit end), bit 5 (transmit empty), bit 4 (break), bit 1 (receive full) or bit 0 (data ready) wherever the written bit is 0. A written 1 leaves that flag as it was. A hardware set event in the same cycle wins over the clear.
- R4: A status read returns the five flags at bits 6, 5, 4, 1 and 0, with zero in all other bits. If control bit 5 (transmit enable) is 1, the same read sets both transmit flags from the next cycle onward. If control bit 5 is 0, the read changes nothing.
- R5: A control write (offset 0x08) with bit 5 clear sets the transmit-end flag.
- R6: Each control write copies its bit 7 to `tx_irq_o` from the next cycle. The value holds until the next control write.
- R7: `rx_irq_o` rises one cycle after a receive-full event while control bit 6 is 1. It falls after a control write with bit 6 clear, or after a status write with bit 1 or bit 0 clear. It never rises while control bit 6 is 0.
- R8: A write to offset 0x0C puts the low byte on `tx_data_o` and raises `tx_valid_o` for the next cycle. It also clears the transmit-empty flag.
- R9: FIFO control bits 7:6 select a trigger level on `rx_trig_o`: 0 gives 1, 1 gives 4, 2 gives 8 and 3 gives 14. A FIFO control write with bit 1 set pulses `fifo_clr_o` for the next cycle.
- R10: A read at offset 0x14 with `rx_level_i` greater than 0 returns `rx_data_i` and pulses `rx_pop_o` in the same cycle. If `rx_level_i - 1` is below the trigger level, the receive-full flag clears. With `rx_level_i` at 0 the read returns 0 and there is no pop.
- R11: A read at offset 0x1C returns `rx_level_i`. A read at offset 0x24 returns 0.
- R12: Offsets 0x28 and above, and any offset with bits 1:0 not zero, read 0 and ignore writes. The baud (0x04) and transmit data (0x0C) offsets also read 0.
- R13: `brk_evt_i` sets the break flag, `rx_full_evt_i` sets the receive-full flag and `rx_ready_evt_i` sets the data-ready flag, each from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Bus write strobe |
| rd_en_i | input | 1 | Bus read strobe |
| addr_i | input | ADDR_W | Byte offset into the register window |
| wdata_i | input | DATA_W | Write data |
| rdata_o | output | DATA_W | Read data, valid in the cycle of `rd_en_i` |
| mode_o | output | 8 | Stored line mode |
| baud_o | output | 8 | Stored baud divisor |
| ctrl_o | output | 8 | Stored control word |
| port_o | output | 8 | Stored port pin control |
| tx_data_o | output | 8 | Last byte written for transmission |
| tx_valid_o | output | 1 | One-cycle strobe marking a new transmit byte |
| tx_irq_o | output | 1 | Transmit interrupt line |
| rx_irq_o | output | 1 | Receive interrupt line |
| fifo_clr_o | output | 1 | One-cycle pulse that empties the receive FIFO |
| rx_trig_o | output | TRIG_W | Receive trigger level |
| rx_level_i | input | LVL_W | Receive FIFO fill level |
| rx_data_i | input | 8 | Receive FIFO head byte |
| rx_pop_o | output | 1 | Removes the head byte from the receive FIFO |
| brk_evt_i | input | 1 | Break detected on the line |
| rx_full_evt_i | input | 1 | Receive FIFO reached its trigger level or timed out |
| rx_ready_evt_i | input | 1 | Receive data ready event |

## Verification
A flag register with the wrong value shows on the very next status read. It can also show as a missing or stuck re-arm of the transmit flags one read later. That is why the bench reads status right after every write or event that should move a flag. A wrong interrupt latch or strobe register shows at `tx_irq_o`, `rx_irq_o`, `tx_valid_o` or `fifo_clr_o` one cycle after the causing access, and the bench samples them there. A wrong trigger decode shows at once on `rx_trig_o`. It also shows as a receive-full flag that clears, or survives, at the wrong fill level after a data read.

// File: rtl/serial_csr_pkg.sv
package serial_csr_pkg;

  localparam int unsigned BYTE_W = 8;
  localparam int unsigned TRIG_W = 5;
  localparam int unsigned N_REGS = 10;

  // register index = offset / 4; neighbours decode by this order
  localparam int unsigned REG_MODE  = 0;
  localparam int unsigned REG_BAUD  = 1;
  localparam int unsigned REG_CTRL  = 2;
  localparam int unsigned REG_TXD   = 3;
  localparam int unsigned REG_STAT  = 4;
  localparam int unsigned REG_RXD   = 5;
  localparam int unsigned REG_FCTL  = 6;
  localparam int unsigned REG_RCNT  = 7;
  localparam int unsigned REG_PORT  = 8;
  localparam int unsigned REG_LSTAT = 9;

  localparam logic [BYTE_W-1:0] MODE_MASK = 8'h7B;
  localparam logic [BYTE_W-1:0] CTRL_MASK = 8'hFA;
  localparam logic [BYTE_W-1:0] PORT_MASK = 8'hF3;

  localparam int unsigned CT_TXIRQ = 7;
  localparam int unsigned CT_RXIE  = 6;
  localparam int unsigned CT_TXEN  = 5;

  localparam int unsigned ST_TEND = 6;
  localparam int unsigned ST_TDE  = 5;
  localparam int unsigned ST_BRK  = 4;
  localparam int unsigned ST_RDF  = 1;
  localparam int unsigned ST_DR   = 0;

  localparam int unsigned FC_CLR = 1;

  // flag vector order: {tend, tde, brk, rdf, dr}
  localparam int unsigned N_FLAGS = 5;
  localparam int unsigned F_TEND = 4;
  localparam int unsigned F_TDE  = 3;
  localparam int unsigned F_BRK  = 2;
  localparam int unsigned F_RDF  = 1;
  localparam int unsigned F_DR   = 0;

  function automatic logic [TRIG_W-1:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'd0:    return TRIG_W'(1);
      2'd1:    return TRIG_W'(4);
      2'd2:    return TRIG_W'(8);
      default: return TRIG_W'(14);
    endcase
  endfunction

  function automatic logic [BYTE_W-1:0] stat_pack(input logic [N_FLAGS-1:0] f);
    logic [BYTE_W-1:0] s;
    s = '0;
    s[ST_TEND] = f[F_TEND];
    s[ST_TDE]  = f[F_TDE];
    s[ST_BRK]  = f[F_BRK];
    s[ST_RDF]  = f[F_RDF];
    s[ST_DR]   = f[F_DR];
    return s;
  endfunction

endpackage

// File: rtl/serial_csr_decode.sv
module serial_csr_decode #(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned N_REGS = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [N_REGS-1:0] sel_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             aligned;
  logic [IDX_W-1:0] idx;

  assign aligned = (addr_i[1:0] == 2'b00);
  assign idx     = addr_i[ADDR_W-1:2];

  for (genvar g = 0; g < N_REGS; g++) begin : g_sel
    assign sel_o[g] = aligned && (idx == IDX_W'(g));
  end

endmodule

// File: rtl/serial_csr_flags.sv
module serial_csr_flags
  import serial_csr_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               stat_wr_i,
  input  logic               stat_rd_i,
  input  logic [BYTE_W-1:0]  wbyte_i,
  input  logic               ctrl_wr_i,
  input  logic               txen_i,
  input  logic               txd_wr_i,
  input  logic               brk_set_i,
  input  logic               rdf_set_i,
  input  logic               dr_set_i,
  input  logic               rdf_drop_i,
  output logic [N_FLAGS-1:0] flags_o
);
  logic [N_FLAGS-1:0] flags_q, clr_v, set_v;
  logic               rearm;

  assign rearm = stat_rd_i && txen_i;

  always_comb begin
    clr_v = '0;
    set_v = '0;
    if (stat_wr_i) begin
      clr_v[F_TEND] = ~wbyte_i[ST_TEND];
      clr_v[F_TDE]  = ~wbyte_i[ST_TDE];
      clr_v[F_BRK]  = ~wbyte_i[ST_BRK];
      clr_v[F_RDF]  = ~wbyte_i[ST_RDF];
      clr_v[F_DR]   = ~wbyte_i[ST_DR];
    end
    if (txd_wr_i)   clr_v[F_TDE] = 1'b1;
    if (rdf_drop_i) clr_v[F_RDF] = 1'b1;
    set_v[F_TEND] = rearm || (ctrl_wr_i && !wbyte_i[CT_TXEN]);
    set_v[F_TDE]  = rearm;
    set_v[F_BRK]  = brk_set_i;
    set_v[F_RDF]  = rdf_set_i;
    set_v[F_DR]   = dr_set_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q         <= '0;
      flags_q[F_TEND] <= 1'b1;
      flags_q[F_TDE]  <= 1'b1;
    end else begin
      flags_q <= (flags_q & ~clr_v) | set_v;
    end
  end

  assign flags_o = flags_q;

  p_w0c_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i && !wbyte_i[ST_BRK] && !brk_set_i |=> !flags_q[F_BRK]);

  p_w1_keep_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_wr_i && wbyte_i[ST_BRK] && !brk_set_i |=> flags_q[F_BRK] == $past(flags_q[F_BRK]));

  p_rearm_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_rd_i && txen_i |=> flags_q[F_TEND] && flags_q[F_TDE]);

  p_tend_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i && !wbyte_i[CT_TXEN] |=> flags_q[F_TEND]);

  p_evt_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dr_set_i |=> flags_q[F_DR]);

endmodule

// File: rtl/serial_csr_intr.sv
module serial_csr_intr (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ctrl_wr_i,
  input  logic txirq_bit_i,
  input  logic rxie_bit_i,
  input  logic rxie_i,
  input  logic stat_wr_i,
  input  logic stat_rdf_bit_i,
  input  logic stat_dr_bit_i,
  input  logic rdf_set_i,
  output logic tx_irq_o,
  output logic rx_irq_o
);
  logic tx_q, rx_q, rx_set, rx_clr;

  assign rx_set = rdf_set_i && rxie_i;
  assign rx_clr = (ctrl_wr_i && !rxie_bit_i) ||
                  (stat_wr_i && (!stat_rdf_bit_i || !stat_dr_bit_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= 1'b0;
      rx_q <= 1'b0;
    end else begin
      if (ctrl_wr_i) tx_q <= txirq_bit_i;
      rx_q <= rx_set || (rx_q && !rx_clr);
    end
  end

  assign tx_irq_o = tx_q;
  assign rx_irq_o = rx_q;

  p_txirq_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr_i |=> tx_irq_o == $past(txirq_bit_i));

  p_rxirq_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_clr && !rx_set |=> !rx_irq_o);

  p_rxirq_gate_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rxie_i && !rx_irq_o |=> !rx_irq_o);

endmodule

// File: rtl/serial_csr_regs.sv
module serial_csr_regs
  import serial_csr_pkg::*;
#(
  parameter int unsigned ADDR_W = 6,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned LVL_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic [7:0]        mode_o,
  output logic [7:0]        baud_o,
  output logic [7:0]        ctrl_o,
  output logic [7:0]        port_o,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  output logic              tx_irq_o,
  output logic              rx_irq_o,
  output logic              fifo_clr_o,
  output logic [TRIG_W-1:0] rx_trig_o,
  input  logic [LVL_W-1:0]  rx_level_i,
  input  logic [7:0]        rx_data_i,
  output logic              rx_pop_o,
  input  logic              brk_evt_i,
  input  logic              rx_full_evt_i,
  input  logic              rx_ready_evt_i
);
  localparam int unsigned CMP_W = (LVL_W > TRIG_W ? LVL_W : TRIG_W) + 1;

  logic [N_REGS-1:0]  sel, wr_sel, rd_sel;
  logic [BYTE_W-1:0]  wbyte;
  logic [BYTE_W-1:0]  mode_q, baud_q, ctrl_q, port_q, txd_q;
  logic [DATA_W-1:0]  fctl_q;
  logic               txv_q, clr_q;
  logic [TRIG_W-1:0]  trig;
  logic [N_FLAGS-1:0] flags;
  logic               pop, rdf_drop;
  logic [CMP_W-1:0]   lvl_after;
  logic [DATA_W-1:0]  rd_val [N_REGS];

  serial_csr_decode #(.ADDR_W(ADDR_W), .N_REGS(N_REGS)) i_decode (
    .addr_i (addr_i),
    .sel_o  (sel)
  );

  assign wr_sel = sel & {N_REGS{wr_en_i}};
  assign rd_sel = sel & {N_REGS{rd_en_i}};
  assign wbyte  = wdata_i[BYTE_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= '0;
      baud_q <= 8'hFF;
      ctrl_q <= 8'h20;
      port_q <= '0;
      fctl_q <= '0;
      txd_q  <= '0;
      txv_q  <= 1'b0;
      clr_q  <= 1'b0;
    end else begin
      if (wr_sel[REG_MODE]) mode_q <= wbyte & MODE_MASK;
      if (wr_sel[REG_BAUD]) baud_q <= wbyte;
      if (wr_sel[REG_CTRL]) ctrl_q <= wbyte & CTRL_MASK;
      if (wr_sel[REG_PORT]) port_q <= wbyte & PORT_MASK;
      if (wr_sel[REG_FCTL]) fctl_q <= wdata_i;
      if (wr_sel[REG_TXD])  txd_q  <= wbyte;
      txv_q <= wr_sel[REG_TXD];
      clr_q <= wr_sel[REG_FCTL] && wdata_i[FC_CLR];
    end
  end

  assign trig      = trig_level(fctl_q[7:6]);
  assign pop       = rd_sel[REG_RXD] && (rx_level_i != '0);
  assign lvl_after = CMP_W'(rx_level_i) - CMP_W'(1);
  assign rdf_drop  = pop && (lvl_after < CMP_W'(trig));

  serial_csr_flags i_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stat_wr_i  (wr_sel[REG_STAT]),
    .stat_rd_i  (rd_sel[REG_STAT]),
    .wbyte_i    (wbyte),
    .ctrl_wr_i  (wr_sel[REG_CTRL]),
    .txen_i     (ctrl_q[CT_TXEN]),
    .txd_wr_i   (wr_sel[REG_TXD]),
    .brk_set_i  (brk_evt_i),
    .rdf_set_i  (rx_full_evt_i),
    .dr_set_i   (rx_ready_evt_i),
    .rdf_drop_i (rdf_drop),
    .flags_o    (flags)
  );

  serial_csr_intr i_intr (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .ctrl_wr_i      (wr_sel[REG_CTRL]),
    .txirq_bit_i    (wbyte[CT_TXIRQ]),
    .rxie_bit_i     (wbyte[CT_RXIE]),
    .rxie_i         (ctrl_q[CT_RXIE]),
    .stat_wr_i      (wr_sel[REG_STAT]),
    .stat_rdf_bit_i (wbyte[ST_RDF]),
    .stat_dr_bit_i  (wbyte[ST_DR]),
    .rdf_set_i      (rx_full_evt_i),
    .tx_irq_o       (tx_irq_o),
    .rx_irq_o       (rx_irq_o)
  );

  // read values per register index; write-only and reserved slots read zero
  assign rd_val[REG_MODE]  = DATA_W'(mode_q);
  assign rd_val[REG_BAUD]  = '0;
  assign rd_val[REG_CTRL]  = DATA_W'(ctrl_q);
  assign rd_val[REG_TXD]   = '0;
  assign rd_val[REG_STAT]  = DATA_W'(stat_pack(flags));
  assign rd_val[REG_RXD]   = pop ? DATA_W'(rx_data_i) : '0;
  assign rd_val[REG_FCTL]  = fctl_q;
  assign rd_val[REG_RCNT]  = DATA_W'(rx_level_i);
  assign rd_val[REG_PORT]  = DATA_W'(port_q);
  assign rd_val[REG_LSTAT] = '0;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < N_REGS; i++) begin
      if (rd_sel[i]) rdata_o = rdata_o | rd_val[i];
    end
  end

  assign mode_o     = mode_q;
  assign baud_o     = baud_q;
  assign ctrl_o     = ctrl_q;
  assign port_o     = port_q;
  assign tx_data_o  = txd_q;
  assign tx_valid_o = txv_q;
  assign fifo_clr_o = clr_q;
  assign rx_trig_o  = trig;
  assign rx_pop_o   = pop;

  p_txv_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> tx_data_o == $past(wdata_i[7:0]));

  p_clr_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fifo_clr_o |-> $past(wr_en_i && addr_i == ADDR_W'(REG_FCTL * 4) && wdata_i[FC_CLR]));

  p_pop_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pop_o |-> rd_en_i && rx_level_i != '0 && rdata_o == DATA_W'(rx_data_i));

  p_unmapped_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_en_i && addr_i[1:0] != 2'b00 |-> rdata_o == '0 && !rx_pop_o);

endmodule

// File: tb/test_serial_csr_regs.sv
module test_serial_csr_regs;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [5:0]  addr_i = '0;
  logic [15:0] wdata_i = '0;
  logic [15:0] rdata_o;
  logic [7:0]  mode_o, baud_o, ctrl_o, port_o, tx_data_o;
  logic        tx_valid_o, tx_irq_o, rx_irq_o, fifo_clr_o, rx_pop_o;
  logic [4:0]  rx_trig_o;
  logic [4:0]  rx_level_i = '0;
  logic [7:0]  rx_data_i = '0;
  logic        brk_evt_i = 1'b0, rx_full_evt_i = 1'b0, rx_ready_evt_i = 1'b0;

  int checks = 0;
  int fails  = 0;

  typedef struct {
    logic [15:0] data;
    logic        pop;
    string       tag;
  } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;

  serial_csr_regs i_serial_csr_regs (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .mode_o(mode_o), .baud_o(baud_o), .ctrl_o(ctrl_o), .port_o(port_o),
    .tx_data_o(tx_data_o), .tx_valid_o(tx_valid_o), .tx_irq_o(tx_irq_o),
    .rx_irq_o(rx_irq_o), .fifo_clr_o(fifo_clr_o), .rx_trig_o(rx_trig_o),
    .rx_level_i(rx_level_i), .rx_data_i(rx_data_i), .rx_pop_o(rx_pop_o),
    .brk_evt_i(brk_evt_i), .rx_full_evt_i(rx_full_evt_i),
    .rx_ready_evt_i(rx_ready_evt_i)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // monitor: compare every read cycle against the scoreboard
  always @(negedge clk) begin
    if (rd_en_i) begin
      if (sb_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard: unexpected read actual=0x%0h expected=none", rdata_o);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        chk({e.tag, " rdata"}, rdata_o, e.data);
        chk({e.tag, " pop"}, 16'(rx_pop_o), 16'(e.pop));
      end
    end
  end

  task automatic wr(input logic [5:0] a, input logic [15:0] d);
    @(posedge clk); #1;
    addr_i = a; wdata_i = d; wr_en_i = 1'b1;
    @(posedge clk); #1;
    wr_en_i = 1'b0;
  endtask

  task automatic rd(input logic [5:0] a, input logic [15:0] exp, input logic pop, input string tag);
    exp_t e;
    @(posedge clk); #1;
    addr_i = a; rd_en_i = 1'b1;
    e.data = exp; e.pop = pop; e.tag = tag;
    sb_q.push_back(e);
    @(posedge clk); #1;
    rd_en_i = 1'b0;
  endtask

  task automatic evt(input logic b, input logic f, input logic r);
    @(posedge clk); #1;
    brk_evt_i = b; rx_full_evt_i = f; rx_ready_evt_i = r;
    @(posedge clk); #1;
    brk_evt_i = 1'b0; rx_full_evt_i = 1'b0; rx_ready_evt_i = 1'b0;
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;

    // R1 reset state
    chk("R1 baud", 16'(baud_o), 16'hFF);
    chk("R1 trig", 16'(rx_trig_o), 16'd1);
    chk("R1 txirq", 16'(tx_irq_o), 16'd0);
    chk("R1 rxirq", 16'(rx_irq_o), 16'd0);
    rd(6'h00, 16'h00, 1'b0, "R1 mode");
    rd(6'h08, 16'h20, 1'b0, "R1 ctrl");
    rd(6'h20, 16'h00, 1'b0, "R1 port");
    rd(6'h18, 16'h0000, 1'b0, "R1 fctl");
    rd(6'h10, 16'h60, 1'b0, "R1 stat");

    // R2 write masks
    wr(6'h00, 16'h00FF); rd(6'h00, 16'h7B, 1'b0, "R2 mode");
    wr(6'h20, 16'h00FF); rd(6'h20, 16'hF3, 1'b0, "R2 port");
    wr(6'h18, 16'h1234); rd(6'h18, 16'h1234, 1'b0, "R2 fctl");
    wr(6'h04, 16'h005A); chk("R2 baud", 16'(baud_o), 16'h5A);
    rd(6'h04, 16'h0, 1'b0, "R12 baud read");

    // R6 control drives tx irq; R2 control mask
    wr(6'h08, 16'h00FF); chk("R6 txirq hi", 16'(tx_irq_o), 16'd1);
    rd(6'h08, 16'hFA, 1'b0, "R2 ctrl");
    chk("R6 txirq hold", 16'(tx_irq_o), 16'd1);
    wr(6'h08, 16'h0020); chk("R6 txirq lo", 16'(tx_irq_o), 16'd0);

    // R8 transmit data
    wr(6'h0C, 16'h00A5);
    chk("R8 valid", 16'(tx_valid_o), 16'd1);
    chk("R8 data", 16'(tx_data_o), 16'hA5);
    step(); chk("R8 valid drop", 16'(tx_valid_o), 16'd0);
    rd(6'h0C, 16'h0, 1'b0, "R12 txd read");
    rd(6'h10, 16'h40, 1'b0, "R8 tde clr");
    rd(6'h10, 16'h60, 1'b0, "R4 rearm");

    // R13 events, R3 write-zero-to-clear
    evt(1'b1, 1'b1, 1'b1);
    chk("R7 rxirq gated", 16'(rx_irq_o), 16'd0);
    rd(6'h10, 16'h73, 1'b0, "R13 all set");
    wr(6'h10, 16'h00EF); rd(6'h10, 16'h63, 1'b0, "R3 brk clr");
    wr(6'h10, 16'h00FF); rd(6'h10, 16'h63, 1'b0, "R3 ones keep");
    wr(6'h10, 16'h00FC); rd(6'h10, 16'h60, 1'b0, "R3 rdf dr clr");
    brk_evt_i = 1'b1;
    wr(6'h10, 16'h00EF);
    brk_evt_i = 1'b0;
    rd(6'h10, 16'h70, 1'b0, "R3 set wins");
    wr(6'h10, 16'h00EF); rd(6'h10, 16'h60, 1'b0, "R3 brk clr2");

    // R4 no rearm when transmitter off; R5 tend set
    wr(6'h08, 16'h0000);
    wr(6'h10, 16'h009F);
    rd(6'h10, 16'h00, 1'b0, "R4 no rearm a");
    rd(6'h10, 16'h00, 1'b0, "R4 no rearm b");
    wr(6'h08, 16'h0000);
    rd(6'h10, 16'h40, 1'b0, "R5 tend set");
    wr(6'h08, 16'h0020);
    rd(6'h10, 16'h40, 1'b0, "R4 read before rearm");
    rd(6'h10, 16'h60, 1'b0, "R4 rearmed");

    // R7 receive interrupt
    wr(6'h08, 16'h0060);
    evt(1'b0, 1'b1, 1'b0); chk("R7 rxirq set", 16'(rx_irq_o), 16'd1);
    wr(6'h10, 16'h00FD);   chk("R7 clr by rdf bit", 16'(rx_irq_o), 16'd0);
    rd(6'h10, 16'h60, 1'b0, "R3 rdf cleared");
    evt(1'b0, 1'b1, 1'b0); chk("R7 rxirq set2", 16'(rx_irq_o), 16'd1);
    wr(6'h10, 16'h00FE);   chk("R7 clr by dr bit", 16'(rx_irq_o), 16'd0);
    rd(6'h10, 16'h62, 1'b0, "R3 rdf kept");
    wr(6'h10, 16'h00FD);
    evt(1'b0, 1'b1, 1'b0); chk("R7 rxirq set3", 16'(rx_irq_o), 16'd1);
    wr(6'h08, 16'h0020);   chk("R7 clr by ctrl", 16'(rx_irq_o), 16'd0);
    evt(1'b0, 1'b1, 1'b0); chk("R7 gated", 16'(rx_irq_o), 16'd0);
    wr(6'h10, 16'h00FD);
    rd(6'h10, 16'h60, 1'b0, "R3 rdf cleared2");

    // R9 trigger decode and fifo clear
    wr(6'h18, 16'h0040); chk("R9 trig4", 16'(rx_trig_o), 16'd4);
    chk("R9 no clr", 16'(fifo_clr_o), 16'd0);
    wr(6'h18, 16'h0080); chk("R9 trig8", 16'(rx_trig_o), 16'd8);
    wr(6'h18, 16'h00C0); chk("R9 trig14", 16'(rx_trig_o), 16'd14);
    wr(6'h18, 16'h00C2); chk("R9 clr pulse", 16'(fifo_clr_o), 16'd1);
    step(); chk("R9 clr drop", 16'(fifo_clr_o), 16'd0);
    rd(6'h18, 16'h00C2, 1'b0, "R9 fctl read");

    // R10 receive data read
    rx_level_i = 5'd14; rx_data_i = 8'h3C;
    evt(1'b0, 1'b1, 1'b0);
    rd(6'h14, 16'h3C, 1'b1, "R10 pop");
    rd(6'h10, 16'h60, 1'b0, "R10 rdf dropped");
    evt(1'b0, 1'b1, 1'b0);
    rx_level_i = 5'd15;
    rd(6'h14, 16'h3C, 1'b1, "R10 pop keep");
    rd(6'h10, 16'h62, 1'b0, "R10 rdf kept");
    wr(6'h10, 16'h00FD);
    rx_level_i = 5'd0;
    rd(6'h14, 16'h0, 1'b0, "R10 empty");

    // R11 count and line status
    rd(6'h1C, 16'h0, 1'b0, "R11 count0");
    rx_level_i = 5'd9;
    rd(6'h1C, 16'h9, 1'b0, "R11 count9");
    rd(6'h24, 16'h0, 1'b0, "R11 lstat");

    // R12 unmapped and misaligned
    rd(6'h28, 16'h0, 1'b0, "R12 0x28");
    rd(6'h3C, 16'h0, 1'b0, "R12 0x3C");
    rd(6'h15, 16'h0, 1'b0, "R12 misaligned rxd");
    wr(6'h28, 16'h00FF);
    wr(6'h01, 16'h0000);
    rd(6'h00, 16'h7B, 1'b0, "R12 mode untouched");
    chk("R12 baud untouched", 16'(baud_o), 16'h5A);

    repeat (3) step();
    chk("scoreboard drained", 16'(sb_q.size()), 16'd0);
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule